// File: doc/BRIEF.md
# Seven-Operand Carry-Save Compressor Array

This block reduces seven unsigned N-bit operands to a pair of vectors whose arithmetic sum equals the sum of all seven operands. No carry propagates across the whole word: the pair is meant to feed a separate final adder, which is not part of this block. The reduction is built from one compressor cell per bit column.

Each cell counts the ones among the seven operand bits of its column with a 7-input ones counter. The counter's three result bits carry weights 2^i, 2^(i+1) and 2^(i+2). The two upper bits leave the cell as forwarded carries, one to the next column and one to the column after that. The lowest bit meets the two carries arriving from the two columns below in a 3:2 stage. That stage yields the column's sum bit and one more bit for the carry vector. The forwarded carries depend only on the cell's own operand bits, so no signal ripples sideways beyond two columns. Two extra tail columns absorb the carries leaving the top operand column, so both outputs are N+3 bits wide.

A parameter selects how the ones counter is built. One choice is a tree of four full adders in three levels. The other is a behavioural population count. Both choices give identical results.

Top module: `comp72_array`

## Requirements
- R1: For every input, the value of sum_o plus carry_o, taken as unsigned numbers, equals the exact sum of the seven operands.
- R2: Let k_i be the number of ones among the seven operand bits of column i. Write k_i = 4*h_i + 2*m_i + l_i. For every column i below WIDTH+2, sum_o[i] equals l_i XOR m_(i-1) XOR h_(i-2).
- R3: For every column i below WIDTH+2, carry_o[i+1] equals the majority of the same three bits l_i, m_(i-1) and h_(i-2).
- R4: Carries that would arrive from below column 0 are tied to 0, and so is every k_j for j >= WIDTH. As a result, carry_o[0] and sum_o[WIDTH+2] are always 0.
- R5: Changing only the operand bits of column j leaves sum_o[k] unchanged for k < j and k > j+2. It leaves carry_o[k] unchanged for k <= j and k > j+3.
- R6: With all seven operands all ones, the outputs still sum to 7*(2^WIDTH-1) with no lost bit.
- R7: COUNTER_STYLE 0, the full-adder tree, and COUNTER_STYLE 1, the population count, produce identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops_i | input | 7 x WIDTH | Seven unsigned operands, packed as [6:0][WIDTH-1:0] |
| sum_o | output | WIDTH+3 | Sum-level vector, one bit per column |
| carry_o | output | WIDTH+3 | Carry vector, bit i+1 driven by column i |

## Verification
A wrong count inside one cell corrupts bits of the output pair only in that column and the two above it. The error appears at once, because the block has no state, so the per-column parity and majority checks name the exact column at fault. A carry routed to the wrong neighbour, or a carry leaking from the incoming side into the outgoing side, breaks the arithmetic total or the locality window around a single toggled column. The bench compares both counter variants against a column-level arithmetic model for each vector.

// File: rtl/comp72_pkg.sv
package comp72_pkg;
   // Result of counting ones among seven bits, weights 4/2/1.
   typedef struct packed {
      logic w2;
      logic w1;
      logic w0;
   } cnt3_t;

   localparam int unsigned NUM_OPS = 7;
endpackage

// File: rtl/fa3_cell.sv
module fa3_cell (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   assign s_o = a_i ^ b_i ^ c_i;
   assign c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/ones7_counter.sv
module ones7_counter
   import comp72_pkg::*;
#(
   parameter int unsigned STYLE = 0
) (
   input  logic [NUM_OPS-1:0] bits_i,
   output cnt3_t              cnt_o
);
   if (STYLE > 1) begin : g_bad_style
      $error("ones7_counter: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_fa_tree
      logic s_a, c_a, s_b, c_b, c_c;
      // level 1: two independent triples
      fa3_cell u_l1a (.a_i(bits_i[0]), .b_i(bits_i[1]), .c_i(bits_i[2]),
                      .s_o(s_a), .c_o(c_a));
      fa3_cell u_l1b (.a_i(bits_i[3]), .b_i(bits_i[4]), .c_i(bits_i[5]),
                      .s_o(s_b), .c_o(c_b));
      // level 2: unit weight
      fa3_cell u_l2  (.a_i(s_a), .b_i(s_b), .c_i(bits_i[6]),
                      .s_o(cnt_o.w0), .c_o(c_c));
      // level 3: weight two
      fa3_cell u_l3  (.a_i(c_a), .b_i(c_b), .c_i(c_c),
                      .s_o(cnt_o.w1), .c_o(cnt_o.w2));
   end else begin : g_popcount
      logic [2:0] tally;
      always_comb begin
         tally = 3'd0;
         for (int k = 0; k < NUM_OPS; k++) begin
            tally = tally + 3'(bits_i[k]);
         end
      end
      assign cnt_o = tally;
   end
endmodule

// File: rtl/comp72_cell.sv
module comp72_cell
   import comp72_pkg::*;
#(
   parameter int unsigned COUNTER_STYLE = 0
) (
   input  logic [NUM_OPS-1:0] prim_i,
   input  logic               cin_near_i,  // from column i-1
   input  logic               cin_far_i,   // from column i-2
   output logic               fwd_near_o,  // to column i+1
   output logic               fwd_far_o,   // to column i+2
   output logic               sum_o,
   output logic               carry_o
);
   cnt3_t cnt;

   ones7_counter #(.STYLE(COUNTER_STYLE)) u_cnt (
      .bits_i (prim_i),
      .cnt_o  (cnt)
   );

   // forwarded carries come from the primaries alone
   assign fwd_near_o = cnt.w1;
   assign fwd_far_o  = cnt.w2;

   fa3_cell u_merge (
      .a_i (cnt.w0),
      .b_i (cin_near_i),
      .c_i (cin_far_i),
      .s_o (sum_o),
      .c_o (carry_o)
   );
endmodule

// File: rtl/comp72_array.sv
module comp72_array
   import comp72_pkg::*;
#(
   parameter int unsigned WIDTH         = 8,
   parameter int unsigned COUNTER_STYLE = 0,
   localparam int unsigned COLS         = WIDTH + 2,
   localparam int unsigned OUTW         = WIDTH + 3
) (
   input  logic [NUM_OPS-1:0][WIDTH-1:0] ops_i,
   output logic [OUTW-1:0]               sum_o,
   output logic [OUTW-1:0]               carry_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("comp72_array: WIDTH must be at least 1");
   end
   if (COUNTER_STYLE > 1) begin : g_bad_style
      $error("comp72_array: COUNTER_STYLE must be 0 or 1");
   end

   logic [WIDTH-1:0] fwd_near;
   logic [WIDTH-1:0] fwd_far;

   for (genvar i = 0; i < COLS; i++) begin : g_col
      logic near_in;
      logic far_in;

      if (i >= 1 && i - 1 < WIDTH) begin : g_near
         assign near_in = fwd_near[i-1];
      end else begin : g_near_tie
         assign near_in = 1'b0;
      end

      if (i >= 2 && i - 2 < WIDTH) begin : g_far
         assign far_in = fwd_far[i-2];
      end else begin : g_far_tie
         assign far_in = 1'b0;
      end

      if (i < WIDTH) begin : g_full
         logic [NUM_OPS-1:0] prim;
         for (genvar t = 0; t < NUM_OPS; t++) begin : g_pick
            assign prim[t] = ops_i[t][i];
         end
         comp72_cell #(.COUNTER_STYLE(COUNTER_STYLE)) u_cell (
            .prim_i     (prim),
            .cin_near_i (near_in),
            .cin_far_i  (far_in),
            .fwd_near_o (fwd_near[i]),
            .fwd_far_o  (fwd_far[i]),
            .sum_o      (sum_o[i]),
            .carry_o    (carry_o[i+1])
         );
      end else begin : g_tail
         // tail column: no primaries, only absorbs carries
         fa3_cell u_tail (
            .a_i (1'b0),
            .b_i (near_in),
            .c_i (far_in),
            .s_o (sum_o[i]),
            .c_o (carry_o[i+1])
         );
      end
   end

   assign sum_o[OUTW-1] = 1'b0;
   assign carry_o[0]    = 1'b0;
endmodule

// File: rtl/comp72_array_chk.sv
module comp72_array_chk
   import comp72_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned OUTW = WIDTH + 3
) (
   input logic [NUM_OPS-1:0][WIDTH-1:0] ops_i,
   input logic [OUTW-1:0]               sum_o,
   input logic [OUTW-1:0]               carry_o
);
   logic [OUTW:0]   total_ops;
   logic [OUTW:0]   total_out;
   logic [OUTW-1:0] par_exp;
   logic [OUTW-1:0] maj_exp;

   always_comb begin
      logic [2:0] cnt [OUTW+1];
      total_ops = '0;
      for (int t = 0; t < NUM_OPS; t++) total_ops = total_ops + (OUTW+1)'(ops_i[t]);
      total_out = (OUTW+1)'(sum_o) + (OUTW+1)'(carry_o);
      for (int i = 0; i <= OUTW; i++) begin
         cnt[i] = 3'd0;
         if (i < WIDTH)
            for (int t = 0; t < NUM_OPS; t++) cnt[i] = cnt[i] + 3'(ops_i[t][i]);
      end
      par_exp = '0;
      maj_exp = '0;
      for (int i = 0; i < OUTW - 1; i++) begin
         logic l, m, h;
         l = cnt[i][0];
         m = (i >= 1) ? cnt[i-1][1] : 1'b0;
         h = (i >= 2) ? cnt[i-2][2] : 1'b0;
         par_exp[i]   = l ^ m ^ h;
         maj_exp[i+1] = (l & m) | (l & h) | (m & h);
      end
   end

   always_comb begin
      // R1
      total_match_chk: assert (total_out == total_ops)
         else $error("R1 outputs sum to %0d, operands to %0d", total_out, total_ops);
      // R2
      column_parity_chk: assert (sum_o == par_exp)
         else $error("R2 sum vector %b, column parity %b", sum_o, par_exp);
      // R3
      column_majority_chk: assert (carry_o == maj_exp)
         else $error("R3 carry vector %b, column majority %b", carry_o, maj_exp);
      // R4
      edge_zero_chk: assert (carry_o[0] == 1'b0 && sum_o[OUTW-1] == 1'b0)
         else $error("R4 edge bits not zero");
   end
endmodule

bind comp72_array comp72_array_chk #(.WIDTH(WIDTH)) u_chk (
   .ops_i   (ops_i),
   .sum_o   (sum_o),
   .carry_o (carry_o)
);

// File: tb/tb_comp72_array.sv
`timescale 1ns/100ps
module tb_comp72_array;
   localparam int W    = 4;
   localparam int OUTW = W + 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [6:0][W-1:0] ops;
   logic [OUTW-1:0]   s_a, c_a, s_b, c_b;
   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   comp72_array #(.WIDTH(W), .COUNTER_STYLE(0)) dut (
      .ops_i(ops), .sum_o(s_a), .carry_o(c_a));
   comp72_array #(.WIDTH(W), .COUNTER_STYLE(1)) dut_beh (
      .ops_i(ops), .sum_o(s_b), .carry_o(c_b));

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // column model built from the requirement text
   task automatic model(output logic [OUTW-1:0] es, output logic [OUTW-1:0] ec);
      int cnt [OUTW+1];
      for (int i = 0; i <= OUTW; i++) begin
         cnt[i] = 0;
         if (i < W) for (int t = 0; t < 7; t++) cnt[i] += int'(ops[t][i]);
      end
      es = '0; ec = '0;
      for (int i = 0; i < OUTW - 1; i++) begin
         int l, m, h;
         l = cnt[i] % 2;
         m = (i >= 1) ? (cnt[i-1] / 2) % 2 : 0;
         h = (i >= 2) ? cnt[i-2] / 4 : 0;
         es[i]   = 1'((l + m + h) % 2);
         ec[i+1] = (l + m + h) >= 2;
      end
   endtask

   task automatic apply_and_check(input logic [6:0][W-1:0] v);
      logic [OUTW-1:0] es, ec;
      longint tot;
      @(posedge clk); ops = v;
      @(negedge clk);
      tot = 0;
      for (int t = 0; t < 7; t++) tot += longint'(v[t]);
      model(es, ec);
      check("R1 total", longint'(s_a) + longint'(c_a), tot);
      check("R2 sum vector", longint'(s_a), longint'(es));
      check("R3 carry vector", longint'(c_a), longint'(ec));
      check("R4 edge bits", longint'({c_a[0], s_a[OUTW-1]}), 0);
      check("R7 style sum", longint'(s_b), longint'(s_a));
      check("R7 style carry", longint'(c_b), longint'(c_a));
   endtask

   initial begin
      logic [6:0][W-1:0] v;
      ops = '0;
      @(negedge clk);
      check("R4 reset-free zero sum", longint'(s_a), 0);
      check("R4 reset-free zero carry", longint'(c_a), 0);

      // R6: all ones
      v = '1;
      apply_and_check(v);
      check("R6 all ones total", longint'(s_a) + longint'(c_a), 7 * ((1 << W) - 1));

      // R4: column 0 only, count 7, tied carries below
      v = '0;
      for (int t = 0; t < 7; t++) v[t] = W'(1);
      apply_and_check(v);
      check("R4 low column sum", longint'(s_a), 7);
      check("R4 low column carry", longint'(c_a), 0);

      // top column only, count 7 -> reaches tail columns
      v = '0;
      for (int t = 0; t < 7; t++) v[t] = W'(1) << (W - 1);
      apply_and_check(v);
      check("R1 top column total", longint'(s_a) + longint'(c_a), 7 << (W - 1));

      // single operand sweep, and walking count per column
      for (int k = 0; k < 8; k++) begin
         for (int j = 0; j < W; j++) begin
            v = '0;
            for (int t = 0; t < k; t++) v[t][j] = 1'b1;
            apply_and_check(v);
         end
      end

      // random sweep
      for (int r = 0; r < 3000; r++) begin
         for (int t = 0; t < 7; t++) v[t] = W'($urandom);
         apply_and_check(v);
      end

      // R5: locality of a single column change
      for (int r = 0; r < 400; r++) begin
         logic [OUTW-1:0] s0, c0;
         int j;
         logic [6:0] flip;
         for (int t = 0; t < 7; t++) v[t] = W'($urandom);
         j = int'($urandom % W);
         flip = 7'($urandom) | 7'd1;
         apply_and_check(v);
         s0 = s_a; c0 = c_a;
         for (int t = 0; t < 7; t++) v[t][j] = v[t][j] ^ flip[t];
         apply_and_check(v);
         for (int k = 0; k < OUTW; k++) begin
            if (k < j || k > j + 2) check("R5 sum locality", longint'(s_a[k]), longint'(s0[k]));
            if (k <= j || k > j + 3) check("R5 carry locality", longint'(c_a[k]), longint'(c0[k]));
         end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule